// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This core fetches, decodes and retires one instruction in every clock cycle. It handles seven instructions: load word, store word, branch-if-equal, and the register-register operations add, subtract, AND and OR.

A main decoder looks only at the opcode and produces a 2-bit operation class. A second decoder turns that class into the ALU function. It reads funct3 and funct7 only for register-register instructions.

Instruction memory and data memory are separate word arrays inside the block, and the environment fills them before reset is released. The only outputs are debug taps. These show the program counter of the instruction now executing and the register-file write that this instruction performs.

Top module: `rv_mini_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter is loaded with 0. This is visible on `dbg_pc` after that edge.
- R2: After any instruction that is not a taken branch, the next program counter is the current one plus 4.
- R3: Branch-if-equal (opcode 1100011) compares its two source registers by subtraction. When they are equal, the next program counter is the current one plus the sign-extended offset {bit31, bit7, bits30:25, bits11:8, 0}. When they differ, R2 applies. The instruction writes no register.
- R4: Opcode 0110011 writes to rd the result of rs1 op rs2. The {funct7, funct3} codes are: 0000000/000 add, 0100000/000 subtract, 0000000/111 AND, 0000000/110 OR. Add and subtract wrap modulo 2^32.
- R5: Load word (opcode 0000011) writes to rd the data-memory word at rs1 plus the sign-extended bits 31:20. The word index is address bits above bit 1.
- R6: Store word (opcode 0100011) writes rs2 into the data-memory word at rs1 plus the sign-extended {bits31:25, bits11:7}. The write takes effect at the rising edge, and the instruction writes no register.
- R7: Register x0 always reads as 0. A write addressed to x0 leaves it at 0.
- R8: `dbg_rf_we` is 1 for register-register and load instructions and 0 for store and branch. A register changes only when this write is enabled.
- R9: In the cycle in which `dbg_pc` shows an instruction, `dbg_rf_idx` and `dbg_rf_data` show that instruction's destination and result. The result is committed at the following rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Address of the instruction executing this cycle |
| dbg_rf_we | output | 1 | Register-file write enable of that instruction |
| dbg_rf_idx | output | 5 | Destination register of that instruction |
| dbg_rf_data | output | 32 | Value written to the destination register |

## Verification
Every register-file write is due in the same cycle as the instruction on `dbg_pc`, since the datapath is combinational from the program counter to the write port. The bench therefore compares PC, write enable, destination and data at the falling edge, before the edge that commits them. The next program counter and the contents of a stored word only appear one edge later. The bench checks them as the next sampled `dbg_pc` and as the data returned by a later load, both against its own instruction-level model. A reset is checked on the first falling edge after the edge that sees `rst` high.

// File: rtl/rvm_pkg.sv
package rvm_pkg;

    localparam int XLEN = 32;

    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;

    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;

    typedef enum logic [1:0] {
        CLS_MEM = 2'b00,
        CLS_BR  = 2'b01,
        CLS_REG = 2'b10
    } op_class_e;

    typedef enum logic [1:0] {
        FN_ADD,
        FN_SUB,
        FN_AND,
        FN_OR
    } alu_fn_e;

    typedef struct packed {
        logic      reg_we;
        logic      use_imm;
        logic      mem_rd;
        logic      mem_wr;
        logic      is_branch;
        logic      mem_to_reg;
        op_class_e cls;
    } ctrl_t;

    typedef struct packed {
        logic [6:0] funct7;
        logic [4:0] rs2;
        logic [4:0] rs1;
        logic [2:0] funct3;
        logic [4:0] rd;
        logic [6:0] opcode;
    } insn_t;

    function automatic logic [XLEN-1:0] imm_load(insn_t i);
        return {{(XLEN-12){i.funct7[6]}}, i.funct7, i.rs2};
    endfunction

    function automatic logic [XLEN-1:0] imm_store(insn_t i);
        return {{(XLEN-12){i.funct7[6]}}, i.funct7, i.rd};
    endfunction

    function automatic logic [XLEN-1:0] imm_branch(insn_t i);
        return {{(XLEN-13){i.funct7[6]}}, i.funct7[6], i.rd[0],
                i.funct7[5:0], i.rd[4:1], 1'b0};
    endfunction

endpackage

// File: rtl/rvm_ctrl.sv
module rvm_ctrl
    import rvm_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output ctrl_t      ctrl,
    output alu_fn_e    alu_fn
);

    // first level: opcode only
    always_comb begin
        ctrl = '0;
        ctrl.cls = CLS_MEM;
        unique case (opcode)
            OPC_REG: begin
                ctrl.reg_we = 1'b1;
                ctrl.cls    = CLS_REG;
            end
            OPC_LOAD: begin
                ctrl.reg_we     = 1'b1;
                ctrl.use_imm    = 1'b1;
                ctrl.mem_rd     = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.cls        = CLS_MEM;
            end
            OPC_STORE: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
                ctrl.cls     = CLS_MEM;
            end
            OPC_BRANCH: begin
                ctrl.is_branch = 1'b1;
                ctrl.cls       = CLS_BR;
            end
            default: ;
        endcase
    end

    // second level: class code, refined by function fields for reg-reg
    always_comb begin
        alu_fn = FN_ADD;
        unique case (ctrl.cls)
            CLS_MEM: alu_fn = FN_ADD;
            CLS_BR:  alu_fn = FN_SUB;
            CLS_REG: begin
                unique case ({funct7, funct3})
                    {F7_BASE, 3'b000}: alu_fn = FN_ADD;
                    {F7_ALT,  3'b000}: alu_fn = FN_SUB;
                    {F7_BASE, 3'b111}: alu_fn = FN_AND;
                    {F7_BASE, 3'b110}: alu_fn = FN_OR;
                    default:           alu_fn = FN_ADD;
                endcase
            end
            default: alu_fn = FN_ADD;
        endcase
    end

endmodule

// File: rtl/rvm_regfile.sv
module rvm_regfile #(
    parameter int NREGS = 32,
    parameter int WIDTH = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [$clog2(NREGS)-1:0] raddr_a,
    input  logic [$clog2(NREGS)-1:0] raddr_b,
    output logic [WIDTH-1:0]         rdata_a,
    output logic [WIDTH-1:0]         rdata_b
);

    localparam int AW = $clog2(NREGS);

    logic [WIDTH-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (we && waddr != AW'(0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == AW'(0)) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == AW'(0)) ? '0 : regs[raddr_b];

endmodule

// File: rtl/rvm_alu.sv
module rvm_alu
    import rvm_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_fn_e          fn,
    output logic [WIDTH-1:0] y,
    output logic             zero
);

    always_comb begin
        unique case (fn)
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/rvm_dmem.sv
module rvm_dmem #(
    parameter int WORDS = 256,
    parameter int WIDTH = 32
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [$clog2(WORDS)-1:0] idx,
    input  logic [WIDTH-1:0]         wdata,
    output logic [WIDTH-1:0]         rdata
);

    logic [WIDTH-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = rd_en ? mem[idx] : '0;

endmodule

// File: rtl/rv_mini_core.sv
module rv_mini_core
    import rvm_pkg::*;
#(
    parameter int IMEM_WORDS = 512,
    parameter int DMEM_WORDS = 256
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] dbg_pc,
    output logic        dbg_rf_we,
    output logic [4:0]  dbg_rf_idx,
    output logic [31:0] dbg_rf_data
);

    localparam int IA_W = $clog2(IMEM_WORDS);
    localparam int DA_W = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] imem [IMEM_WORDS];

    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) begin
            imem[i] = '0;
        end
    end

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] br_target;
    logic            pc_src;

    insn_t           insn;
    logic [6:0]      opc;
    ctrl_t           ctrl;
    alu_fn_e         alu_fn;
    logic [XLEN-1:0] rd1;
    logic [XLEN-1:0] rd2;
    logic [XLEN-1:0] imm;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] mem_rdata;
    logic [XLEN-1:0] wb_data;
    logic            dm_we;

    // fetch
    assign insn = insn_t'(imem[pc_q[IA_W+1:2]]);
    assign opc  = insn.opcode;

    rvm_ctrl u_ctrl (
        .opcode (opc),
        .funct3 (insn.funct3),
        .funct7 (insn.funct7),
        .ctrl   (ctrl),
        .alu_fn (alu_fn)
    );

    rvm_regfile #(.NREGS(32), .WIDTH(XLEN)) u_rf (
        .clk     (clk),
        .we      (ctrl.reg_we),
        .waddr   (insn.rd),
        .wdata   (wb_data),
        .raddr_a (insn.rs1),
        .raddr_b (insn.rs2),
        .rdata_a (rd1),
        .rdata_b (rd2)
    );

    assign imm   = ctrl.mem_wr ? imm_store(insn) : imm_load(insn);
    assign alu_b = ctrl.use_imm ? imm : rd2;

    rvm_alu #(.WIDTH(XLEN)) u_alu (
        .a    (rd1),
        .b    (alu_b),
        .fn   (alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign dm_we = ctrl.mem_wr;

    rvm_dmem #(.WORDS(DMEM_WORDS), .WIDTH(XLEN)) u_dmem (
        .clk   (clk),
        .wr_en (dm_we),
        .rd_en (ctrl.mem_rd),
        .idx   (alu_y[DA_W+1:2]),
        .wdata (rd2),
        .rdata (mem_rdata)
    );

    assign wb_data = ctrl.mem_to_reg ? mem_rdata : alu_y;

    // next program counter
    assign pc_plus4  = pc_q + XLEN'(4);
    assign br_target = pc_q + imm_branch(insn);
    assign pc_src    = ctrl.is_branch & alu_zero;
    assign pc_next   = pc_src ? br_target : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign dbg_pc      = pc_q;
    assign dbg_rf_we   = ctrl.reg_we;
    assign dbg_rf_idx  = insn.rd;
    assign dbg_rf_data = wb_data;

endmodule

// File: rtl/rv_mini_core_chk.sv
module rv_mini_core_chk
    import rvm_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] dbg_pc,
    input logic        dbg_we,
    input logic [6:0]  opc,
    input logic [4:0]  rs1,
    input logic [4:0]  rs2,
    input logic [31:0] rd1,
    input logic [31:0] rd2,
    input logic        pc_src,
    input logic [31:0] br_target,
    input logic        dm_we,
    input alu_fn_e     alu_fn
);

    // R1
    a_r1_pc_reset: assert property (@(posedge clk)
        rst |=> dbg_pc == 32'd0);

    // R2
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        !pc_src |=> dbg_pc == $past(dbg_pc) + 32'd4);

    // R3
    a_r3_eq_taken: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_BRANCH && rd1 == rd2) |-> pc_src);

    // R3
    a_r3_target: assert property (@(posedge clk) disable iff (rst)
        pc_src |=> dbg_pc == $past(br_target));

    // R5
    a_r5_addr_add: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_LOAD || opc == OPC_STORE) |-> alu_fn == FN_ADD);

    // R6
    a_r6_store_we: assert property (@(posedge clk) disable iff (rst)
        opc == OPC_STORE |-> dm_we);

    // R7
    a_r7_x0_read_a: assert property (@(posedge clk) disable iff (rst)
        rs1 == 5'd0 |-> rd1 == 32'd0);

    // R7
    a_r7_x0_read_b: assert property (@(posedge clk) disable iff (rst)
        rs2 == 5'd0 |-> rd2 == 32'd0);

    // R8
    a_r8_no_write: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_STORE || opc == OPC_BRANCH) |-> !dbg_we);

endmodule

bind rv_mini_core rv_mini_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .dbg_pc    (dbg_pc),
    .dbg_we    (dbg_rf_we),
    .opc       (opc),
    .rs1       (insn.rs1),
    .rs2       (insn.rs2),
    .rd1       (rd1),
    .rd2       (rd2),
    .pc_src    (pc_src),
    .br_target (br_target),
    .dm_we     (dm_we),
    .alu_fn    (alu_fn)
);

// File: tb/rv_mini_core_test.sv
`timescale 1ns/1ps
module rv_mini_core_test;

    localparam int IMW = 512;
    localparam int DMW = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] dbg_pc;
    logic        dbg_rf_we;
    logic [4:0]  dbg_rf_idx;
    logic [31:0] dbg_rf_data;

    always #2 clk = ~clk;

    rv_mini_core #(.IMEM_WORDS(IMW), .DMEM_WORDS(DMW)) uut (
        .clk         (clk),
        .rst         (rst),
        .dbg_pc      (dbg_pc),
        .dbg_rf_we   (dbg_rf_we),
        .dbg_rf_idx  (dbg_rf_idx),
        .dbg_rf_data (dbg_rf_data)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] prog [IMW];
    logic [31:0] m_rf [32];
    logic [31:0] m_dm [DMW];
    int          plen = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic emit(input logic [31:0] w);
        prog[plen] = w;
        plen++;
    endtask

    function automatic logic [31:0] enc_r(int op, int rd, int a, int b);
        logic [6:0] f7;
        logic [2:0] f3;
        case (op)
            0: begin f7 = 7'b0000000; f3 = 3'b000; end
            1: begin f7 = 7'b0100000; f3 = 3'b000; end
            2: begin f7 = 7'b0000000; f3 = 3'b111; end
            default: begin f7 = 7'b0000000; f3 = 3'b110; end
        endcase
        return {f7, 5'(b), 5'(a), f3, 5'(rd), 7'b0110011};
    endfunction

    function automatic logic [31:0] enc_lw(int rd, int base, int off);
        logic [11:0] i = 12'(off);
        return {i, 5'(base), 3'b010, 5'(rd), 7'b0000011};
    endfunction

    function automatic logic [31:0] enc_sw(int src, int base, int off);
        logic [11:0] i = 12'(off);
        return {i[11:5], 5'(src), 5'(base), 3'b010, i[4:0], 7'b0100011};
    endfunction

    function automatic logic [31:0] enc_beq(int a, int b, int off);
        logic [12:0] o = 13'(off);
        return {o[12], o[10:5], 5'(b), 5'(a), 3'b000, o[4:1], o[11], 7'b1100011};
    endfunction

    function automatic logic [31:0] sext12(logic [11:0] v);
        return {{20{v[11]}}, v};
    endfunction

    // one cycle of comparison against the instruction-level model
    task automatic step_and_check(inout logic [31:0] mpc);
        logic [31:0] w;
        logic [6:0]  op;
        logic [4:0]  rd, ra, rb;
        logic [31:0] va, vb, res, addr, npc;
        logic        we;
        string       tg;
        w   = prog[mpc[10:2]];
        op  = w[6:0];
        rd  = w[11:7];
        ra  = w[19:15];
        rb  = w[24:20];
        va  = (ra == 0) ? 32'd0 : m_rf[ra];
        vb  = (rb == 0) ? 32'd0 : m_rf[rb];
        we  = 1'b0;
        res = 32'd0;
        npc = mpc + 32'd4;
        tg  = "R2";
        case (op)
            7'b0110011: begin
                we = 1'b1;
                case ({w[31:25], w[14:12]})
                    10'b0000000_000: res = va + vb;
                    10'b0100000_000: res = va - vb;
                    10'b0000000_111: res = va & vb;
                    default:         res = va | vb;
                endcase
                tg = (rd == 0 || ra == 0 || rb == 0) ? "R7" : "R4";
            end
            7'b0000011: begin
                we   = 1'b1;
                addr = va + sext12(w[31:20]);
                res  = m_dm[addr[9:2]];
                tg   = (rd == 0 || ra == 0) ? "R7" : "R5";
            end
            7'b0100011: begin
                addr = va + sext12({w[31:25], w[11:7]});
                tg   = "R6";
            end
            7'b1100011: begin
                if (va == vb)
                    npc = mpc + {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
                tg = "R3";
            end
            default: ;
        endcase
        chk((op == 7'b1100011) ? "R3" : "R2", dbg_pc, mpc);
        chk("R8", {31'd0, dbg_rf_we}, {31'd0, we});
        if (we) begin
            chk("R9", {27'd0, dbg_rf_idx}, {27'd0, rd});
            chk(tg, dbg_rf_data, res);
            if (rd != 0) m_rf[rd] = res;
        end
        if (op == 7'b0100011) m_dm[addr[9:2]] = vb;
        mpc = npc;
    endtask

    // watchdog
    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual %h expected %h", 32'd0, 32'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] mpc;
        logic [31:0] end_pc;
        logic [31:0] vals [9];
        int          r;

        vals = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000,
                 32'h7FFF_FFFF, 32'h1234_5678, 32'hA5A5_A5A5, 32'h0000_0003,
                 32'h0000_0140};
        for (int i = 0; i < DMW; i++) m_dm[i] = 32'(i) * 32'h9E37_79B9;
        for (int i = 0; i < 9; i++) m_dm[i] = vals[i];
        for (int i = 0; i < IMW; i++) prog[i] = 32'd0;
        for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;

        // operand loads: x1..x8 data, x9 base
        for (int k = 0; k < 9; k++) emit(enc_lw(k + 1, 0, 4 * k));
        // all operand pairs through all four functions
        r = 11;
        for (int a = 1; a <= 8; a++)
            for (int b = 1; b <= 8; b++)
                for (int op = 0; op < 4; op++) begin
                    emit(enc_r(op, r, a, b));
                    r = (r == 31) ? 11 : r + 1;
                end
        // stores with negative, positive and far offsets, read back by loads
        emit(enc_sw(6, 9, -8));
        emit(enc_lw(11, 9, -8));
        emit(enc_sw(7, 9, 4));
        emit(enc_lw(12, 9, 4));
        emit(enc_sw(5, 9, -320));
        emit(enc_lw(18, 0, 0));
        emit(enc_sw(4, 0, 1020));
        emit(enc_lw(19, 0, 1020));
        // x0 write ignored, x0 reads zero
        emit(enc_lw(0, 0, 4));
        emit(enc_r(0, 13, 0, 2));
        emit(enc_r(1, 14, 2, 0));
        emit(enc_r(3, 0, 6, 7));
        emit(enc_r(0, 20, 0, 0));
        // branches: taken forward, not taken
        emit(enc_beq(1, 1, 8));
        emit(enc_r(0, 15, 2, 2));
        emit(enc_beq(2, 3, 8));
        emit(enc_r(0, 16, 2, 2));
        // backward loop of three passes
        emit(enc_r(0, 17, 8, 0));
        emit(enc_r(1, 17, 17, 2));
        emit(enc_beq(17, 0, 8));
        emit(enc_beq(0, 0, -8));
        emit(enc_r(0, 21, 17, 5));
        end_pc = 32'(plen * 4);
        emit(enc_beq(0, 0, 0));

        #1;
        for (int i = 0; i < IMW; i++) uut.imem[i] = prog[i];
        for (int i = 0; i < DMW; i++) uut.u_dmem.mem[i] = m_dm[i];

        repeat (3) @(negedge clk);
        chk("R1", dbg_pc, 32'd0);
        rst = 1'b0;
        mpc = 32'd0;
        for (int c = 0; c < 2000; c++) begin
            step_and_check(mpc);
            @(negedge clk);
            if (mpc == end_pc) break;
        end
        // self-loop holds
        for (int c = 0; c < 3; c++) begin
            step_and_check(mpc);
            @(negedge clk);
        end
        // reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        chk("R1", dbg_pc, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R2", dbg_pc, 32'd4);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule